// File: doc/BRIEF.md
# Three-Stage Self-Routing Packet Network (8 x 8)

This block moves packets from eight input ports to eight output ports through three stages of 2x2 switches, four switches per stage. Every packet carries a 3-bit destination address next to its payload. Each switch looks at one address bit only: the first stage uses the most significant bit, the last stage the least significant. Bit value 0 sends the packet to the switch's upper terminal, 1 to its lower one. No central controller exists; the path follows from the address alone. The links between stages are wired as a perfect shuffle, so a packet always leaves at the output port whose index equals its destination.

Each switch input has a small queue. Blocked packets wait in their queue and never move backward. A packet offered on an input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` for an input falls when that input's first-stage queue is full. A sender that sees `in_ready` low must hold the same destination and payload until acceptance. Outputs have no ready signal: a packet shown with `out_valid` high for one cycle is delivered and gone. When two queued packets at a switch want the same terminal, one passes and the other waits. The winner is picked by a round-robin pointer per output terminal, and the pointer moves to the loser after each conflict. An optional counter totals the delivered packets.

Top module: `dnet_delta`

## Requirements
- R1: After reset `out_valid` is all zero, `in_ready` is all one and `delivered_count` is zero.
- R2: A packet with destination d leaves only at output port d, and `out_dest` of that port shows d.
- R3: Every accepted packet leaves exactly once with its payload unchanged. Nothing is lost or duplicated, including under back-pressure.
- R4: A packet that meets no conflict and no full queue is accepted at edge c and shows `out_valid` after edge c+3.
- R5: When every input sends each cycle to destination (i+k) mod 8, for any fixed k, all inputs keep `in_ready` high and every packet sees the 3-cycle latency.
- R6: When traffic converges on one output, `in_ready` of some inputs falls. An offered packet is held by the sender and later accepted without loss.
- R7: Inputs 0 and 4 feed the same first-stage switch, with input 0 on its upper terminal. Two packets sent on them in the same cycle to the same destination leave with latencies 3 and 4. The first such tie after reset goes to input 0, and the next tie goes to input 4.
- R8: Packets from one input to one destination leave in the order they were accepted.
- R9: No packet leaves fewer than 3 cycles after its acceptance.
- R10: With the counter enabled, `delivered_count` equals the number of packets that have shown `out_valid`, one cycle after each delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 8 | Per-input offer of a packet |
| in_ready | output | 8 | Per-input acceptance; low when the entry queue is full |
| in_dest | input | 8x3 | Destination address per input |
| in_data | input | 8x16 | Payload per input |
| out_valid | output | 8 | Per-output delivery strobe, one cycle per packet |
| out_dest | output | 8x3 | Destination address carried by the delivered packet |
| out_data | output | 8x16 | Payload of the delivered packet |
| delivered_count | output | 32 | Running total of delivered packets (zero when disabled) |

## Verification
Cyclic-shift traffic at full rate on all inputs is conflict-free in this wiring. It separates correct pipelining (exact 3-cycle latency, `in_ready` never low) from a design that stalls or misroutes. A single same-cycle pair from inputs 0 and 4 to one destination forces a first-stage conflict. Repeating the pair shows whether the arbiter alternates. All inputs aimed at one port fill the queues and exercise back-pressure and the hold rule. Random destinations then check exactly-once delivery, per-flow order and the counter across mixed contention.

// File: rtl/dnet_pkg.sv
package dnet_pkg;

  // Which of a switch's two inputs owns a tie on an output terminal.
  typedef enum logic {
    PICK_UPPER = 1'b0,
    PICK_LOWER = 1'b1
  } pick_t;

  // Perfect-shuffle: rotate a line index left by one within `bits` bits.
  function automatic int shuffle_pos(input int idx, input int bits);
    int mask;
    mask = (1 << bits) - 1;
    return ((idx << 1) | (idx >> (bits - 1))) & mask;
  endfunction

endpackage

// File: rtl/dnet_fifo.sv
module dnet_fifo #(
  parameter int W     = 19,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         nonempty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] fill;

  assign head     = mem[rd_ptr];
  assign nonempty = (fill != '0);
  assign full     = (fill == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/dnet_switch.sv
module dnet_switch
  import dnet_pkg::*;
#(
  parameter int PW  = 19,
  parameter int SEL = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    hv,
  input  logic [PW-1:0] hpkt [2],
  input  logic [1:0]    space,
  output logic [1:0]    ovld,
  output logic [PW-1:0] opkt [2],
  output logic [1:0]    pop
);
  logic [1:0] rq [2];
  logic       contend [2];
  pick_t      win [2];
  pick_t      prio [2];

  always_comb begin
    pop  = '0;
    ovld = '0;
    for (int b = 0; b < 2; b++) begin
      rq[b][0]   = hv[0] && (hpkt[0][SEL] == b[0]);
      rq[b][1]   = hv[1] && (hpkt[1][SEL] == b[0]);
      contend[b] = &rq[b];
      if (contend[b])    win[b] = prio[b];
      else if (rq[b][1]) win[b] = PICK_LOWER;
      else               win[b] = PICK_UPPER;
      ovld[b] = (|rq[b]) && space[b];
      opkt[b] = (win[b] == PICK_LOWER) ? hpkt[1] : hpkt[0];
      if (ovld[b]) pop[win[b]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (!rst_n)
        prio[b] <= PICK_UPPER;
      else if (ovld[b] && contend[b])
        prio[b] <= (win[b] == PICK_UPPER) ? PICK_LOWER : PICK_UPPER;
    end
  end
endmodule

// File: rtl/dnet_delta.sv
module dnet_delta
  import dnet_pkg::*;
#(
  parameter int N_LOG    = 3,
  parameter int DW       = 16,
  parameter int DEPTH    = 2,
  parameter bit COUNT_EN = 1'b1,
  parameter int CNT_W    = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [(1<<N_LOG)-1:0]             in_valid,
  output logic [(1<<N_LOG)-1:0]             in_ready,
  input  logic [(1<<N_LOG)-1:0][N_LOG-1:0]  in_dest,
  input  logic [(1<<N_LOG)-1:0][DW-1:0]     in_data,
  output logic [(1<<N_LOG)-1:0]             out_valid,
  output logic [(1<<N_LOG)-1:0][N_LOG-1:0]  out_dest,
  output logic [(1<<N_LOG)-1:0][DW-1:0]     out_data,
  output logic [CNT_W-1:0]                  delivered_count
);
  localparam int PORTS  = 1 << N_LOG;
  localparam int STAGES = N_LOG;
  localparam int AW     = N_LOG;
  localparam int PW     = AW + DW;
  localparam int NV_W   = $clog2(PORTS + 1);

  logic          q_push   [STAGES][PORTS];
  logic [PW-1:0] q_wdata  [STAGES][PORTS];
  logic          q_pop    [STAGES][PORTS];
  logic [PW-1:0] q_head   [STAGES][PORTS];
  logic          q_ne     [STAGES][PORTS];
  logic          q_full   [STAGES][PORTS];
  logic          sw_vld   [STAGES][PORTS];
  logic [PW-1:0] sw_pkt   [STAGES][PORTS];
  logic          sw_space [STAGES][PORTS];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    // Queues at switch inputs
    for (genvar j = 0; j < PORTS; j++) begin : g_q
      dnet_fifo #(.W(PW), .DEPTH(DEPTH)) u_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (q_push[s][j]),
        .wdata    (q_wdata[s][j]),
        .pop      (q_pop[s][j]),
        .head     (q_head[s][j]),
        .nonempty (q_ne[s][j]),
        .full     (q_full[s][j])
      );
    end

    // Switch column; stage s steers on address bit AW-1-s
    for (genvar k = 0; k < PORTS / 2; k++) begin : g_sw
      logic [1:0]    hv, sp, ov, pp;
      logic [PW-1:0] hin [2];
      logic [PW-1:0] op  [2];

      for (genvar b = 0; b < 2; b++) begin : g_t
        assign hv[b]   = q_ne[s][2*k+b];
        assign hin[b]  = q_head[s][2*k+b];
        assign sp[b]   = sw_space[s][2*k+b];
        assign sw_vld[s][2*k+b] = ov[b];
        assign sw_pkt[s][2*k+b] = op[b];
        assign q_pop[s][2*k+b]  = pp[b];
      end

      dnet_switch #(.PW(PW), .SEL(DW + AW - 1 - s)) u_sw (
        .clk   (clk),
        .rst_n (rst_n),
        .hv    (hv),
        .hpkt  (hin),
        .space (sp),
        .ovld  (ov),
        .opkt  (op),
        .pop   (pp)
      );
    end

    // Shuffle wiring into this stage's queues
    for (genvar j = 0; j < PORTS; j++) begin : g_link
      localparam int P = shuffle_pos(j, N_LOG);
      if (s == 0) begin : g_entry
        assign q_push[0][P]  = in_valid[j] && !q_full[0][P];
        assign q_wdata[0][P] = {in_dest[j], in_data[j]};
        assign in_ready[j]   = !q_full[0][P];
      end else begin : g_inner
        assign q_push[s][P]       = sw_vld[s-1][j];
        assign q_wdata[s][P]      = sw_pkt[s-1][j];
        assign sw_space[s-1][j]   = !q_full[s][P];
      end
    end
  end

  // Outputs never back-pressure
  for (genvar j = 0; j < PORTS; j++) begin : g_exit
    assign sw_space[STAGES-1][j] = 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < PORTS; j++) begin
      if (!rst_n) begin
        out_valid[j] <= 1'b0;
        out_dest[j]  <= '0;
        out_data[j]  <= '0;
      end else begin
        out_valid[j] <= sw_vld[STAGES-1][j];
        out_dest[j]  <= sw_pkt[STAGES-1][j][PW-1:DW];
        out_data[j]  <= sw_pkt[STAGES-1][j][DW-1:0];
      end
    end
  end

  if (COUNT_EN) begin : g_cnt
    logic [NV_W-1:0]  nvalid;
    logic [CNT_W-1:0] total;

    always_comb begin
      nvalid = '0;
      for (int j = 0; j < PORTS; j++) nvalid = nvalid + NV_W'(out_valid[j]);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) total <= '0;
      else        total <= total + CNT_W'(nvalid);
    end
    assign delivered_count = total;
  end else begin : g_nocnt
    assign delivered_count = '0;
  end
endmodule

// File: rtl/dnet_delta_chk.sv
module dnet_delta_chk #(
  parameter int N_LOG    = 3,
  parameter int DEPTH    = 2,
  parameter bit COUNT_EN = 1'b1,
  parameter int CNT_W    = 32
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [(1<<N_LOG)-1:0]             in_valid,
  input logic [(1<<N_LOG)-1:0]             in_ready,
  input logic [(1<<N_LOG)-1:0]             out_valid,
  input logic [(1<<N_LOG)-1:0][N_LOG-1:0]  out_dest,
  input logic [CNT_W-1:0]                  delivered_count
);
  localparam int PORTS = 1 << N_LOG;
  localparam int CAP   = N_LOG * PORTS * DEPTH + PORTS;

  int acc, h1, h2, h3, dsum;
  int n_acc_now, n_out;
  logic [PORTS-1:0] bad_port;

  always_comb begin
    n_acc_now = $countones(in_valid & in_ready);
    n_out     = $countones(out_valid);
    for (int p = 0; p < PORTS; p++)
      bad_port[p] = out_valid[p] && (out_dest[p] != N_LOG'(p));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= 0; h1 <= 0; h2 <= 0; h3 <= 0; dsum <= 0;
    end else begin
      acc  <= acc + n_acc_now;
      h1   <= acc;
      h2   <= h1;
      h3   <= h2;
      dsum <= dsum + n_out;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_valid == '0 && in_ready == '1));

  a_r2_port_match: assert property (@(posedge clk) disable iff (!rst_n)
    bad_port == '0);

  a_r9_min_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (dsum + n_out) <= h3);

  a_r3_backlog_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (acc - dsum) <= CAP);

  if (COUNT_EN) begin : g_cnt_chk
    a_r10_counter_track: assert property (@(posedge clk) disable iff (!rst_n)
      delivered_count == CNT_W'(dsum));
  end
endmodule

bind dnet_delta dnet_delta_chk #(
  .N_LOG(N_LOG), .DEPTH(DEPTH), .COUNT_EN(COUNT_EN), .CNT_W(CNT_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .out_valid       (out_valid),
  .out_dest        (out_dest),
  .delivered_count (delivered_count)
);

// File: tb/tb_dnet_delta.sv
module tb_dnet_delta;
  localparam int PORTS = 8;
  localparam int AW    = 3;
  localparam int DW    = 16;
  localparam int MAXID = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PORTS-1:0]         in_valid = '0;
  logic [PORTS-1:0]         in_ready;
  logic [PORTS-1:0][AW-1:0] in_dest = '0;
  logic [PORTS-1:0][DW-1:0] in_data = '0;
  logic [PORTS-1:0]         out_valid;
  logic [PORTS-1:0][AW-1:0] out_dest;
  logic [PORTS-1:0][DW-1:0] out_data;
  logic [31:0]              delivered_count;

  dnet_delta dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_dest(out_dest), .out_data(out_data),
    .delivered_count(delivered_count)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  bit finished = 0;

  // Reference bookkeeping
  int exp_dest [MAXID];
  int src_of   [MAXID];
  int acc_cyc  [MAXID];
  int lat_of   [MAXID];
  bit sent     [MAXID];
  bit got      [MAXID];
  int last_id  [PORTS][PORTS];
  int next_id = 0;
  int n_got = 0;
  bit strict = 0;
  bit saw_stall = 0;

  bit pend   [PORTS];
  int pid    [PORTS];
  bit want_v [PORTS];
  int want_d [PORTS];

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, actual, expected, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // One bench cycle: offer packets at the falling edge, note acceptance.
  task automatic step();
    @(negedge clk);
    for (int p = 0; p < PORTS; p++) begin
      if (!pend[p] && want_v[p]) begin
        pend[p] = 1;
        pid[p] = next_id;
        exp_dest[next_id] = want_d[p];
        src_of[next_id] = p;
        next_id++;
      end
      in_valid[p] = pend[p];
      in_dest[p]  = AW'(pend[p] ? exp_dest[pid[p]] : 0);
      in_data[p]  = DW'(pend[p] ? pid[p] : 0);
    end
    #1;
    for (int p = 0; p < PORTS; p++) begin
      if (pend[p]) begin
        if (in_ready[p]) begin
          sent[pid[p]] = 1;
          acc_cyc[pid[p]] = cyc + 1;
          pend[p] = 0;
        end else begin
          saw_stall = 1;
          if (strict) check(0, "R5", "in_ready low under shift traffic", 0, 1);
        end
      end
    end
  endtask

  task automatic clear_wants();
    for (int p = 0; p < PORTS; p++) begin want_v[p] = 0; want_d[p] = 0; end
  endtask

  task automatic idle(input int n);
    clear_wants();
    repeat (n) step();
  endtask

  // Delivery monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < PORTS; p++) begin
        if (out_valid[p]) begin
          int id, lat;
          id = int'(out_data[p]);
          if (id >= next_id || !sent[id]) begin
            check(0, "R3", "unknown payload delivered", id, -1);
          end else begin
            check(!got[id], "R3", "duplicate delivery of id", id, -1);
            check(exp_dest[id] == p, "R2", "delivered at port", p, exp_dest[id]);
            check(int'(out_dest[p]) == p, "R2", "out_dest at port", int'(out_dest[p]), p);
            lat = cyc - acc_cyc[id];
            check(lat >= 3, "R9", "latency", lat, 3);
            if (strict) check(lat == 3, "R4", "unblocked latency", lat, 3);
            check(id > last_id[src_of[id]][p], "R8", "flow order id", id, last_id[src_of[id]][p] + 1);
            last_id[src_of[id]][p] = id;
            lat_of[id] = lat;
            got[id] = 1;
            n_got++;
          end
        end
      end
    end
  end

  task automatic check_all_delivered(input string tag);
    int missing;
    missing = 0;
    for (int i = 0; i < next_id; i++) if (sent[i] && !got[i]) missing++;
    check(missing == 0, tag, "packets still missing after drain", missing, 0);
  endtask

  initial begin
    for (int a = 0; a < PORTS; a++)
      for (int b = 0; b < PORTS; b++) last_id[a][b] = -1;
    for (int p = 0; p < PORTS; p++) pend[p] = 0;
    clear_wants();

    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
    check(in_ready == '1, "R1", "in_ready after reset", int'(in_ready), 255);
    check(delivered_count == 0, "R1", "delivered_count after reset", int'(delivered_count), 0);

    // R7: tie at first-stage switch 0, upper input wins first
    begin
      int a0, a4;
      clear_wants();
      want_v[0] = 1; want_d[0] = 0; want_v[4] = 1; want_d[4] = 0;
      a0 = next_id; a4 = next_id + 1;
      step();
      idle(10);
      check(got[a0] && lat_of[a0] == 3, "R7", "first tie, input 0 latency", lat_of[a0], 3);
      check(got[a4] && lat_of[a4] == 4, "R7", "first tie, input 4 latency", lat_of[a4], 4);
      // second tie goes to input 4
      clear_wants();
      want_v[0] = 1; want_d[0] = 0; want_v[4] = 1; want_d[4] = 0;
      a0 = next_id; a4 = next_id + 1;
      step();
      idle(10);
      check(got[a4] && lat_of[a4] == 3, "R7", "second tie, input 4 latency", lat_of[a4], 3);
      check(got[a0] && lat_of[a0] == 4, "R7", "second tie, input 0 latency", lat_of[a0], 4);
    end

    // R4: a lone packet
    begin
      int id;
      strict = 1;
      clear_wants();
      want_v[5] = 1; want_d[5] = 2;
      id = next_id;
      step();
      idle(8);
      check(got[id], "R4", "lone packet delivered", int'(got[id]), 1);
      strict = 0;
    end

    // R5: cyclic shifts at full rate, all inputs
    for (int k = 0; k < PORTS; k++) begin
      strict = 1;
      for (int p = 0; p < PORTS; p++) begin want_v[p] = 1; want_d[p] = (p + k) % PORTS; end
      repeat (16) step();
      idle(8);
      strict = 0;
    end
    check_all_delivered("R5");

    // R6: everything to one port
    saw_stall = 0;
    for (int p = 0; p < PORTS; p++) begin want_v[p] = 1; want_d[p] = 3; end
    repeat (40) step();
    check(saw_stall, "R6", "in_ready fell under convergence", int'(saw_stall), 1);
    idle(150);
    check_all_delivered("R6");

    // R3/R8: random destinations and gaps
    for (int c = 0; c < 300; c++) begin
      for (int p = 0; p < PORTS; p++) begin
        want_v[p] = ($urandom_range(0, 3) != 0);
        want_d[p] = $urandom_range(0, PORTS - 1);
      end
      step();
    end
    idle(150);
    check_all_delivered("R3");

    // R10: counter agrees with observed deliveries
    check(int'(delivered_count) == n_got, "R10", "delivered_count", int'(delivered_count), n_got);
    check(n_got == next_id, "R3", "total delivered vs offered", n_got, next_id);

    finish_run();
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end
endmodule